// File: doc/BRIEF.md
# Two-Frame Transmit Fetch Sequencer

This block sits on the memory-fetch side of a transmit path and decides when the next outgoing frame may be pulled from memory into the transmit FIFO. Each fetch is abstracted as a start request, which is a valid/ready handshake carrying a frame tag, followed by a one-cycle `fetch_done` pulse once the whole frame has been written into the FIFO. The FIFO controller returns one status pulse per frame, in transmission order, after the MAC has consumed that frame's end-of-frame. The sequencer pairs each status with its frame and hands finished frames back for descriptor release on a valid/ready output stream, strictly in fetch order.

Up to `MAX_INFLIGHT` frames (two by default) may be in flight, counted from acceptance of the fetch request until the release handshake. When `cfg_overlap` is clear, fetches are fully serial: the next request waits until the previous frame has been released. When `cfg_overlap` is set, the next request is raised as soon as the previous fetch finishes, without waiting for its status. The sequencer stalls when the in-flight limit is reached. Every status code counts as completion, including underflow and flush, so an aborted frame can never wedge the pipeline.

Back-pressure rules: `req_valid` stays high with a stable `req_tag` until `req_ready` is sampled high. `rel_valid` stays high with stable `rel_tag` and `rel_code` until `rel_ready` is sampled high. A handshake completes on a rising clock edge at which both valid and ready are high.

Top module: `tx_fetch_seq`

## Requirements
- R1: While `rst_n` is low and in the cycle after release, `req_valid` and `rel_valid` are low. The first accepted request after reset carries tag 0.
- R2: With `cfg_overlap` clear, no request is raised while a frame is in flight. After the release handshake, `req_valid` rises one cycle later, provided `work_avail` is high and no fetch is still running.
- R3: With `cfg_overlap` set and fewer than `MAX_INFLIGHT` frames in flight, `req_valid` rises one cycle after the `fetch_done` pulse of the previous frame.
- R4: At most `MAX_INFLIGHT` (2) frames are in flight. At the limit no request is raised, even after statuses arrive. The request rises one cycle after the release handshake that frees a slot.
- R5: Only one fetch runs at a time. After a request is accepted, no new request is raised until `fetch_done`, even if that frame has already been given status and released. The new request then rises one cycle after `fetch_done`.
- R6: A status pulse is attached to the oldest in-flight frame that has no status yet. `rel_valid` is high in the cycle after the status edge, presenting that frame's tag. Releases follow fetch order.
- R7: The 2-bit status code is carried unchanged to `rel_code` (0 ok, 1 underflow, 2 flushed, 3 aborted). Every code, including underflow and flushed, completes the frame.
- R8: A status pulse arriving when no in-flight frame is awaiting status is ignored. It raises no release and changes no later frame's code.
- R9: Once raised, `req_valid` holds with a stable `req_tag` until accepted, even if `work_avail` drops. Tags increase by one per accepted request, modulo 2^`TAG_W`.
- R10: While `rel_ready` is low, `rel_valid`, `rel_tag` and `rel_code` hold their values.
- R11: With `work_avail` low, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_overlap | input | 1 | Allow the next fetch to overlap transmission of the current frame |
| work_avail | input | 1 | A descriptor is waiting to be fetched |
| req_valid | output | 1 | Fetch start request valid |
| req_ready | input | 1 | Fetch engine accepts the request |
| req_tag | output | TAG_W | Tag of the frame to fetch |
| fetch_done | input | 1 | One-cycle pulse: current fetch fully written into the FIFO |
| st_valid | input | 1 | One-cycle pulse: status for the next frame in order |
| st_code | input | 2 | Status code accompanying `st_valid` |
| rel_valid | output | 1 | A frame is ready for descriptor release |
| rel_ready | input | 1 | Release consumer accepts |
| rel_tag | output | TAG_W | Tag of the released frame |
| rel_code | output | 2 | Status code of the released frame |

## Verification
Each result has a fixed latency, and the bench checks it on the exact cycle. Requests are registered, so `req_valid` appears one cycle after the edge that made it allowed: after reset with `work_avail` high, one cycle after `fetch_done` in overlap mode, and one cycle after the release handshake in serial mode. Release visibility is combinational from the queue, so `rel_valid` is already high at the falling edge that follows the status edge. Inputs are driven and outputs sampled on falling edges, and each task checks both the cycle before a due change (still low) and the cycle it is due (high). Hold and stall windows are checked on every cycle across several cycles.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  typedef enum logic [1:0] {
    TX_OK        = 2'd0,
    TX_UNDERFLOW = 2'd1,
    TX_FLUSHED   = 2'd2,
    TX_ABORTED   = 2'd3
  } tx_stat_e;
endpackage

// File: rtl/tfs_issue.sv
// Raises fetch requests and tracks the single running fetch.
module tfs_issue #(
  parameter int MAX_INFLIGHT = 2,
  parameter int TAG_W        = 4,
  parameter int CW           = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_overlap,
  input  logic             work_avail,
  input  logic             req_ready,
  input  logic             fetch_done,
  input  logic [CW-1:0]    inflight,
  output logic             req_valid,
  output logic [TAG_W-1:0] req_tag,
  output logic             issue_fire,
  output logic             fetching
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_INFLIGHT);

  logic             req_q;
  logic             fetch_q;
  logic [TAG_W-1:0] tag_q;
  logic             room;
  logic             allowed;

  // serial mode needs an empty pipeline; overlap mode only needs a free slot
  assign room    = (inflight < LIMIT) && (cfg_overlap || (inflight == '0));
  assign allowed = work_avail && !req_q && !fetch_q && room;

  assign issue_fire = req_q && req_ready;
  assign req_valid  = req_q;
  assign req_tag    = tag_q;
  assign fetching   = fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      fetch_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      if (allowed)         req_q <= 1'b1;
      else if (issue_fire) req_q <= 1'b0;

      if (issue_fire)      fetch_q <= 1'b1;
      else if (fetch_done) fetch_q <= 1'b0;

      if (issue_fire)      tag_q <= tag_q + 1'b1;
    end
  end
endmodule

// File: rtl/tfs_order_q.sv
// Ordered in-flight queue: tags pushed at issue, codes filled in arrival order.
module tfs_order_q
  import tfs_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int TAG_W = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag,
  input  logic             st_valid,
  input  tx_stat_e         st_code,
  input  logic             pop,
  output logic [CW-1:0]    count,
  output logic             head_ready,
  output logic [TAG_W-1:0] head_tag,
  output tx_stat_e         head_code
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] DEPTH_S = (PW + 1)'(DEPTH);

  logic [PW-1:0] hp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] nst_q;
  logic          st_acc;
  logic [PW-1:0] wr_idx;
  logic [PW-1:0] st_idx;

  logic [DEPTH-1:0][TAG_W-1:0] tag_v;
  logic [DEPTH-1:0][1:0]       code_v;

  function automatic logic [PW-1:0] wrap(input logic [PW:0] s);
    if (s >= DEPTH_S) return PW'(s - DEPTH_S);
    return PW'(s);
  endfunction

  // statuses only bind to frames still lacking one
  assign st_acc = st_valid && (nst_q < cnt_q);
  assign wr_idx = wrap((PW + 1)'(hp_q) + (PW + 1)'(cnt_q));
  assign st_idx = wrap((PW + 1)'(hp_q) + (PW + 1)'(nst_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= '0;
      cnt_q <= '0;
      nst_q <= '0;
    end else begin
      if (pop) hp_q <= wrap((PW + 1)'(hp_q) + (PW + 1)'(1));
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      nst_q <= nst_q + CW'(st_acc) - CW'(pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [TAG_W-1:0] tag_r;
    logic [1:0]       code_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_r  <= '0;
        code_r <= TX_OK;
      end else begin
        if (push && (wr_idx == PW'(i)))   tag_r  <= push_tag;
        if (st_acc && (st_idx == PW'(i))) code_r <= st_code;
      end
    end
    assign tag_v[i]  = tag_r;
    assign code_v[i] = code_r;
  end

  assign count      = cnt_q;
  assign head_ready = (nst_q != '0);
  assign head_tag   = tag_v[hp_q];
  assign head_code  = tx_stat_e'(code_v[hp_q]);
endmodule

// File: rtl/tfs_release.sv
// Release port: presents the head frame once its status is known.
module tfs_release
  import tfs_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             head_ready,
  input  logic [TAG_W-1:0] head_tag,
  input  tx_stat_e         head_code,
  input  logic             rel_ready,
  output logic             rel_valid,
  output logic [TAG_W-1:0] rel_tag,
  output logic [1:0]       rel_code,
  output logic             pop
);
  assign rel_valid = head_ready;
  assign rel_tag   = head_tag;
  assign rel_code  = head_code;
  assign pop       = head_ready && rel_ready;
endmodule

// File: rtl/tx_fetch_seq.sv
module tx_fetch_seq
  import tfs_pkg::*;
#(
  parameter int MAX_INFLIGHT = 2,
  parameter int TAG_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_overlap,
  input  logic             work_avail,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [TAG_W-1:0] req_tag,
  input  logic             fetch_done,
  input  logic             st_valid,
  input  logic [1:0]       st_code,
  output logic             rel_valid,
  input  logic             rel_ready,
  output logic [TAG_W-1:0] rel_tag,
  output logic [1:0]       rel_code
);
  localparam int CW = $clog2(MAX_INFLIGHT + 1);

  logic [CW-1:0]    inflight;
  logic             issue_fire;
  logic             fetching;
  logic             pop;
  logic             head_ready;
  logic [TAG_W-1:0] head_tag;
  tx_stat_e         head_code;

  tfs_issue #(.MAX_INFLIGHT(MAX_INFLIGHT), .TAG_W(TAG_W), .CW(CW)) u_issue (
    .clk(clk), .rst_n(rst_n), .cfg_overlap(cfg_overlap), .work_avail(work_avail),
    .req_ready(req_ready), .fetch_done(fetch_done), .inflight(inflight),
    .req_valid(req_valid), .req_tag(req_tag), .issue_fire(issue_fire),
    .fetching(fetching)
  );

  tfs_order_q #(.DEPTH(MAX_INFLIGHT), .TAG_W(TAG_W), .CW(CW)) u_q (
    .clk(clk), .rst_n(rst_n), .push(issue_fire), .push_tag(req_tag),
    .st_valid(st_valid), .st_code(tx_stat_e'(st_code)), .pop(pop),
    .count(inflight), .head_ready(head_ready), .head_tag(head_tag),
    .head_code(head_code)
  );

  tfs_release #(.TAG_W(TAG_W)) u_rel (
    .head_ready(head_ready), .head_tag(head_tag), .head_code(head_code),
    .rel_ready(rel_ready), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .rel_code(rel_code), .pop(pop)
  );
endmodule

// File: rtl/tfs_chk.sv
module tfs_chk #(
  parameter int MAX_INFLIGHT = 2,
  parameter int TAG_W        = 4,
  parameter int CW           = $clog2(MAX_INFLIGHT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_overlap,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             rel_valid,
  input logic             rel_ready,
  input logic [TAG_W-1:0] rel_tag,
  input logic [1:0]       rel_code,
  input logic [CW-1:0]    inflight,
  input logic             fetching
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_INFLIGHT);

  logic [TAG_W-1:0] exp_req;
  logic [TAG_W-1:0] exp_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_req <= '0;
      exp_rel <= '0;
    end else begin
      if (req_valid && req_ready) exp_req <= exp_req + 1'b1;
      if (rel_valid && rel_ready) exp_rel <= exp_rel + 1'b1;
    end
  end

  p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= LIMIT);
  p_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(inflight) < LIMIT));
  p_serial_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && !$past(cfg_overlap)) |-> ($past(inflight) == '0));
  p_one_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(fetching));
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_tag)));
  p_req_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_tag == exp_req));
  p_rel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_tag) && $stable(rel_code)));
  p_rel_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_tag == exp_rel));
endmodule

bind tx_fetch_seq tfs_chk #(.MAX_INFLIGHT(MAX_INFLIGHT), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_overlap(cfg_overlap),
  .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
  .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_tag(rel_tag),
  .rel_code(rel_code), .inflight(inflight), .fetching(fetching)
);

// File: tb/sim_tx_fetch_seq.sv
`timescale 1ns/1ps
module sim_tx_fetch_seq;
  localparam int TAG_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_overlap = 1'b0;
  logic             work_avail = 1'b0;
  logic             req_valid;
  logic             req_ready = 1'b0;
  logic [TAG_W-1:0] req_tag;
  logic             fetch_done = 1'b0;
  logic             st_valid = 1'b0;
  logic [1:0]       st_code = 2'd0;
  logic             rel_valid;
  logic             rel_ready = 1'b0;
  logic [TAG_W-1:0] rel_tag;
  logic [1:0]       rel_code;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  tx_fetch_seq #(.MAX_INFLIGHT(2), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_overlap(cfg_overlap), .work_avail(work_avail),
    .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
    .fetch_done(fetch_done), .st_valid(st_valid), .st_code(st_code),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_tag(rel_tag),
    .rel_code(rel_code)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit ovl, input bit work);
    rst_n = 1'b0; req_ready = 1'b0; fetch_done = 1'b0; st_valid = 1'b0;
    rel_ready = 1'b0; cfg_overlap = ovl; work_avail = work;
    tick(); tick();
    chk("R1", "req_valid in reset", int'(req_valid), 0);
    chk("R1", "rel_valid in reset", int'(rel_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic accept_req(input int tag, input string rq);
    chk(rq, "req_valid before accept", int'(req_valid), 1);
    chk(rq, "req_tag", int'(req_tag), tag);
    req_ready = 1'b1;
    tick();
    req_ready = 1'b0;
    chk(rq, "req_valid after accept", int'(req_valid), 0);
  endtask

  task automatic pulse_done();
    fetch_done = 1'b1; tick(); fetch_done = 1'b0;
  endtask

  task automatic pulse_status(input int code);
    st_valid = 1'b1; st_code = 2'(code); tick(); st_valid = 1'b0;
  endtask

  task automatic release_chk(input int tag, input int code, input string rq);
    chk(rq, "rel_valid", int'(rel_valid), 1);
    chk(rq, "rel_tag", int'(rel_tag), tag);
    chk(rq, "rel_code", int'(rel_code), code);
    rel_ready = 1'b1; tick(); rel_ready = 1'b0;
  endtask

  // serial mode, idle gating, request hold
  task automatic t_serial();
    do_reset(1'b0, 1'b0);
    tick(); tick(); tick();
    chk("R11", "no request without work", int'(req_valid), 0);
    chk("R1", "rel_valid after reset", int'(rel_valid), 0);
    work_avail = 1'b1; tick();
    chk("R1", "first request up", int'(req_valid), 1);
    chk("R1", "first tag", int'(req_tag), 0);
    work_avail = 1'b0; tick();
    chk("R9", "request held after work drops", int'(req_valid), 1);
    chk("R9", "tag held", int'(req_tag), 0);
    accept_req(0, "R9");
    work_avail = 1'b1;
    pulse_done();
    for (int i = 0; i < 4; i++) begin
      chk("R2", "serial: no request before release", int'(req_valid), 0);
      tick();
    end
    pulse_status(0);
    release_chk(0, 0, "R6");
    chk("R2", "request not yet up after release", int'(req_valid), 0);
    tick();
    chk("R2", "request one cycle after release", int'(req_valid), 1);
    chk("R2", "next tag", int'(req_tag), 1);
  endtask

  // overlap mode, two in flight, stall, in-order release
  task automatic t_overlap();
    do_reset(1'b1, 1'b1);
    tick();
    accept_req(0, "R3");
    pulse_done();
    chk("R3", "not yet up after done", int'(req_valid), 0);
    tick();
    chk("R3", "overlap request after done", int'(req_valid), 1);
    accept_req(1, "R3");
    pulse_done();
    for (int i = 0; i < 3; i++) begin
      chk("R4", "stall at two in flight", int'(req_valid), 0);
      tick();
    end
    pulse_status(0);
    pulse_status(2);
    chk("R4", "still stalled with statuses pending release", int'(req_valid), 0);
    release_chk(0, 0, "R6");
    chk("R4", "not yet up after freeing release", int'(req_valid), 0);
    tick();
    chk("R4", "resume after slot frees", int'(req_valid), 1);
    chk("R4", "resume tag", int'(req_tag), 2);
    release_chk(1, 2, "R7");
    chk("R6", "queue empty after two releases", int'(rel_valid), 0);
  endtask

  // stray statuses
  task automatic t_stray();
    do_reset(1'b0, 1'b0);
    tick();
    pulse_status(3);
    chk("R8", "stray status on empty", int'(rel_valid), 0);
    work_avail = 1'b1; tick();
    accept_req(0, "R8");
    pulse_done();
    pulse_status(1);
    pulse_status(0);
    release_chk(0, 1, "R7");
    chk("R8", "extra status made no release", int'(rel_valid), 0);
    tick();
    accept_req(1, "R8");
    pulse_done();
    chk("R8", "no release before own status", int'(rel_valid), 0);
    pulse_status(3);
    release_chk(1, 3, "R8");
  endtask

  // release back-pressure
  task automatic t_backpressure();
    do_reset(1'b0, 1'b1);
    tick();
    accept_req(0, "R10");
    pulse_done();
    pulse_status(2);
    for (int i = 0; i < 3; i++) begin
      chk("R10", "rel_valid held", int'(rel_valid), 1);
      chk("R10", "rel_tag held", int'(rel_tag), 0);
      chk("R10", "rel_code held", int'(rel_code), 2);
      chk("R2", "no request while unreleased", int'(req_valid), 0);
      tick();
    end
    release_chk(0, 2, "R10");
  endtask

  // status before fetch completes
  task automatic t_early_status();
    do_reset(1'b1, 1'b1);
    tick();
    accept_req(0, "R5");
    pulse_status(2);
    release_chk(0, 2, "R5");
    for (int i = 0; i < 2; i++) begin
      chk("R5", "no request while fetch runs", int'(req_valid), 0);
      tick();
    end
    pulse_done();
    chk("R5", "not yet up after done", int'(req_valid), 0);
    tick();
    chk("R5", "request after done", int'(req_valid), 1);
    chk("R5", "tag after done", int'(req_tag), 1);
  endtask

  // tag wrap across many frames
  task automatic t_wrap();
    do_reset(1'b1, 1'b1);
    tick();
    for (int i = 0; i < 18; i++) begin
      accept_req(i % 16, "R9");
      pulse_done();
      pulse_status(i % 4);
      release_chk(i % 16, i % 4, "R9");
    end
  endtask

  initial begin
    t_serial();
    t_overlap();
    t_stray();
    t_backpressure();
    t_early_status();
    t_wrap();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule